// File: doc/BRIEF.md
# Pipelined No-Turnaround Synchronous SRAM

This block models a synchronous burst SRAM whose command path and write-data path are offset by two clock edges. Reads, writes and deselects can therefore be issued on consecutive cycles with no idle turnaround cycle. A read returns its word through an output register one edge after its command. A write takes its data two edges after its command, and the data bus is held undriven during that data phase. The shared data bus is split into an input, an output and a drive-enable signal. An asynchronous output enable gates only the drive-enable.

The array holds `2**AW` words. Each word has four lanes of eight data bits plus one parity bit, and each lane has its own active-low write select. An internal two-bit burst sequencer lets one loaded address serve up to four accesses. The sequence is linear or interleaved, picked when the burst is loaded. A global active-low clock enable freezes the whole block.

Top module: `nt_sram`

## Requirements
- R1: While `rst_n` is low at a rising edge, the pipeline is cleared. After that edge `d_oe` is 0 and `d_out` is all zeros.
- R2: At a rising edge where `clk_en_n` is 1, no state changes. This covers the pipeline stages, the burst sequencer, the output register and the array. A burst that is frozen resumes where it stopped.
- R3: An access starts at an enabled edge with `adv_ld_n`=0 and all chip enables active (`ce1_n`=0, `ce2`=1, `ce3_n`=0). `we_n`=1 makes it a read. The word at `addr` appears on `d_out` after the next enabled edge. `d_oe` is then 1 while `oe_n` is 0.
- R4: `oe_n` acts combinationally on `d_oe`, with no clock edge involved. While `oe_n` is 1, `d_oe` is 0.
- R5: An enabled edge with `adv_ld_n`=0 and any chip enable inactive is a deselect. After the following enabled edge, `d_oe` is 0.
- R6: For a write (`we_n`=0), `d_oe` is 0 after the next enabled edge, whatever `oe_n` is. The data on `d_in` is sampled and stored at the enabled edge after that.
- R7: Lane i is bits 9i+8 down to 9i of the word, and bit 9i+8 is its parity bit. A write stores lane i only when `bw_n[i]` is 0; other lanes keep their contents. `bw_n` is sampled with each command or advance.
- R8: An enabled edge with `adv_ld_n`=1 during a burst issues the next access. The burst mode is `burst_ilv`, sampled at load. With mode 0 (linear), the n-th advance uses address bits [1:0] = (base + n) mod 4, and the upper bits are unchanged.
- R9: With `burst_ilv`=1 at load (interleaved), the n-th advance uses address bits [1:0] = base[1:0] XOR (n mod 4).
- R10: During an advance, the chip enables and `we_n` are ignored. Every access of a burst has the read or write type captured at load.
- R11: A read of an address issued on the cycle right after a write to it returns the newly written lanes, merged with the stored unselected lanes.
- R12: An advance with no burst loaded, for example right after a deselect or reset, starts no access. `d_oe` stays 0 and `d_out` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| clk_en_n | input | 1 | Active-low clock qualifier |
| ce1_n | input | 1 | Chip enable, active low |
| ce2 | input | 1 | Chip enable, active high |
| ce3_n | input | 1 | Chip enable, active low |
| adv_ld_n | input | 1 | 0 = load new command, 1 = advance burst |
| we_n | input | 1 | 0 = write, 1 = read (sampled on load) |
| bw_n | input | LANES | Active-low lane write selects |
| burst_ilv | input | 1 | Burst order, 0 linear, 1 interleaved (sampled on load) |
| addr | input | AW | Word address |
| oe_n | input | 1 | Asynchronous active-low output enable |
| d_in | input | LANES*LANE_W | Write data, taken in the data phase |
| d_out | output | LANES*LANE_W | Registered read data |
| d_oe | output | 1 | Bus drive enable for `d_out` |

## Verification
The bench builds the block with `AW`=6 and keeps the lane defaults, giving a 64-word array. Every address in it fits a reference memory held in the bench. The small depth makes it cheap to land bursts on bases whose low bits force the four-word wrap, in both linear and interleaved order. All four lane selects are kept, so partial writes can mix new and stored lanes in one word, including on the forwarding path where a read follows a write to the same address.

// File: rtl/nt_sram_pkg.sv
// Package: shared types and the burst address-order function.
// Assumes a burst counter of BURST_CNT_W bits and that the address is wider.
package nt_sram_pkg;

    localparam int BURST_CNT_W = 2;

    typedef enum logic {
        BURST_LINEAR     = 1'b0,
        BURST_INTERLEAVE = 1'b1
    } burst_mode_e;

    // Low address bits of the access at a given burst step
    function automatic logic [BURST_CNT_W-1:0] burst_offset(
        input logic [BURST_CNT_W-1:0] base,
        input logic [BURST_CNT_W-1:0] step,
        input burst_mode_e            mode
    );
        if (mode == BURST_INTERLEAVE) begin
            return base ^ step;
        end
        return base + step;
    endfunction

endpackage

// File: rtl/nt_sram_seq.sv
// Module: command stage. Decodes load, deselect and advance at each enabled
// edge, runs the burst sequencer and holds the first pipeline stage.
// Assumes AW > BURST_CNT_W. State changes only when en is high.
module nt_sram_seq
    import nt_sram_pkg::*;
#(
    parameter int AW    = 10,
    parameter int LANES = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             sel,
    input  logic             adv_ld_n,
    input  logic             we_n,
    input  logic [LANES-1:0] bw_n,
    input  logic             mode,
    input  logic [AW-1:0]    addr,
    output logic             s1_vld,
    output logic             s1_wr,
    output logic [AW-1:0]    s1_addr,
    output logic [LANES-1:0] s1_bw_n
);

    logic                   burst_act;
    logic                   burst_wr;
    burst_mode_e            mode_q;
    logic [AW-1:0]          base_q;
    logic [BURST_CNT_W-1:0] cnt_q;
    logic [BURST_CNT_W-1:0] step_nxt;
    logic [AW-1:0]          adv_addr;

    // Next burst step and the address it selects
    always_comb begin
        step_nxt = cnt_q + 1'b1;
        adv_addr = {base_q[AW-1:BURST_CNT_W],
                    burst_offset(base_q[BURST_CNT_W-1:0], step_nxt, mode_q)};
    end

    // Command decode, burst state and first pipeline stage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_vld    <= 1'b0;
            s1_wr     <= 1'b0;
            s1_addr   <= '0;
            s1_bw_n   <= '1;
            burst_act <= 1'b0;
            burst_wr  <= 1'b0;
            mode_q    <= BURST_LINEAR;
            base_q    <= '0;
            cnt_q     <= '0;
        end else if (en) begin
            if (!adv_ld_n) begin
                if (sel) begin
                    s1_vld    <= 1'b1;
                    s1_wr     <= !we_n;
                    s1_addr   <= addr;
                    s1_bw_n   <= bw_n;
                    burst_act <= 1'b1;
                    burst_wr  <= !we_n;
                    mode_q    <= burst_mode_e'(mode);
                    base_q    <= addr;
                    cnt_q     <= '0;
                end else begin
                    s1_vld    <= 1'b0;
                    burst_act <= 1'b0;
                end
            end else if (burst_act) begin
                s1_vld  <= 1'b1;
                s1_wr   <= burst_wr;
                s1_addr <= adv_addr;
                s1_bw_n <= bw_n;
                cnt_q   <= step_nxt;
            end else begin
                s1_vld <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/nt_sram_drive.sv
// Module: second pipeline stage. Holds the access whose data phase is in
// progress and derives the bus drive enable from it and the output enable.
// Assumes oe_n may change at any time; it is not registered.
module nt_sram_drive #(
    parameter int AW    = 10,
    parameter int LANES = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             s1_vld,
    input  logic             s1_wr,
    input  logic [AW-1:0]    s1_addr,
    input  logic [LANES-1:0] s1_bw_n,
    input  logic             oe_n,
    output logic             s2_vld,
    output logic             s2_wr,
    output logic [AW-1:0]    s2_addr,
    output logic [LANES-1:0] s2_bw_n,
    output logic             d_oe
);

    // Data-phase stage register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s2_vld  <= 1'b0;
            s2_wr   <= 1'b0;
            s2_addr <= '0;
            s2_bw_n <= '1;
        end else if (en) begin
            s2_vld  <= s1_vld;
            s2_wr   <= s1_wr;
            s2_addr <= s1_addr;
            s2_bw_n <= s1_bw_n;
        end
    end

    // Drive only for a read data phase with the output enable asserted
    always_comb begin
        d_oe = s2_vld && !s2_wr && !oe_n;
    end

endmodule

// File: rtl/nt_sram_array.sv
// Module: lane-split storage array with the registered read port.
// A write to the same word in the same edge is forwarded into the read
// register lane by lane. Assumes one write and one read per edge at most.
module nt_sram_array #(
    parameter int AW     = 10,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    en,
    input  logic                    wr_vld,
    input  logic [AW-1:0]           wr_addr,
    input  logic [LANES-1:0]        wr_bw_n,
    input  logic [LANES*LANE_W-1:0] wr_data,
    input  logic                    rd_vld,
    input  logic [AW-1:0]           rd_addr,
    output logic [LANES*LANE_W-1:0] rd_q
);

    localparam int DEPTH = 1 << AW;

    logic fwd;

    // Read and write of the same word on one edge
    always_comb begin
        fwd = wr_vld && rd_vld && (wr_addr == rd_addr);
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] mem [DEPTH];
        logic [LANE_W-1:0] lane_q;
        logic              lane_we;

        // Lane write strobe
        always_comb begin
            lane_we = en && wr_vld && !wr_bw_n[g];
        end

        // Lane storage write
        always_ff @(posedge clk) begin
            if (lane_we) begin
                mem[wr_addr] <= wr_data[g*LANE_W +: LANE_W];
            end
        end

        // Lane output register with same-edge forwarding
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                lane_q <= '0;
            end else if (en && rd_vld) begin
                if (fwd && !wr_bw_n[g]) begin
                    lane_q <= wr_data[g*LANE_W +: LANE_W];
                end else begin
                    lane_q <= mem[rd_addr];
                end
            end
        end

        assign rd_q[g*LANE_W +: LANE_W] = lane_q;
    end

endmodule

// File: rtl/nt_sram.sv
// Module: top of the pipelined no-turnaround SRAM. Wires the command stage,
// the data-phase stage and the array. Writes commit from the data-phase
// stage with d_in; reads load the output register from the command stage.
// Assumes the caller drives d_in only while d_oe is low.
module nt_sram #(
    parameter int AW     = 10,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clk_en_n,
    input  logic                    ce1_n,
    input  logic                    ce2,
    input  logic                    ce3_n,
    input  logic                    adv_ld_n,
    input  logic                    we_n,
    input  logic [LANES-1:0]        bw_n,
    input  logic                    burst_ilv,
    input  logic [AW-1:0]           addr,
    input  logic                    oe_n,
    input  logic [LANES*LANE_W-1:0] d_in,
    output logic [LANES*LANE_W-1:0] d_out,
    output logic                    d_oe
);

    logic             en;
    logic             sel_all;
    logic             s1_vld;
    logic             s1_wr;
    logic [AW-1:0]    s1_addr;
    logic [LANES-1:0] s1_bw_n;
    logic             s2_vld;
    logic             s2_wr;
    logic [AW-1:0]    s2_addr;
    logic [LANES-1:0] s2_bw_n;

    // Clock qualifier and chip select decode
    always_comb begin
        en      = !clk_en_n;
        sel_all = !ce1_n && ce2 && !ce3_n;
    end

    nt_sram_seq #(.AW(AW), .LANES(LANES)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en),
        .sel      (sel_all),
        .adv_ld_n (adv_ld_n),
        .we_n     (we_n),
        .bw_n     (bw_n),
        .mode     (burst_ilv),
        .addr     (addr),
        .s1_vld   (s1_vld),
        .s1_wr    (s1_wr),
        .s1_addr  (s1_addr),
        .s1_bw_n  (s1_bw_n)
    );

    nt_sram_drive #(.AW(AW), .LANES(LANES)) u_drive (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (en),
        .s1_vld  (s1_vld),
        .s1_wr   (s1_wr),
        .s1_addr (s1_addr),
        .s1_bw_n (s1_bw_n),
        .oe_n    (oe_n),
        .s2_vld  (s2_vld),
        .s2_wr   (s2_wr),
        .s2_addr (s2_addr),
        .s2_bw_n (s2_bw_n),
        .d_oe    (d_oe)
    );

    nt_sram_array #(.AW(AW), .LANES(LANES), .LANE_W(LANE_W)) u_array (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (en),
        .wr_vld  (s2_vld && s2_wr),
        .wr_addr (s2_addr),
        .wr_bw_n (s2_bw_n),
        .wr_data (d_in),
        .rd_vld  (s1_vld && !s1_wr),
        .rd_addr (s1_addr),
        .rd_q    (d_out)
    );

endmodule

// File: rtl/nt_sram_chk.sv
// Module: protocol checker for nt_sram, attached with bind.
// Assumes it observes the top's ports and its data-phase stage flags.
module nt_sram_chk #(
    parameter int DW = 36
) (
    input logic          clk,
    input logic          rst_n,
    input logic          clk_en_n,
    input logic          adv_ld_n,
    input logic          we_n,
    input logic          sel_all,
    input logic          oe_n,
    input logic          s2_vld,
    input logic          s2_wr,
    input logic [DW-1:0] d_out,
    input logic          d_oe
);

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> !d_oe);                                              // R1

    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        clk_en_n |=> $stable(d_out));                                   // R2

    AST_READ_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!clk_en_n && !adv_ld_n && sel_all && we_n && rst_n, 2) &&
        $past(!clk_en_n && rst_n) && !oe_n |-> d_oe);                   // R3

    AST_OE_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |-> !d_oe);                                                // R4

    AST_DESEL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!clk_en_n && !adv_ld_n && !sel_all && rst_n, 2) &&
        $past(!clk_en_n && rst_n) |-> !d_oe);                           // R5

    AST_WR_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (s2_vld && s2_wr) |-> !d_oe);                                   // R6

endmodule

bind nt_sram nt_sram_chk #(.DW(LANES*LANE_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .clk_en_n (clk_en_n),
    .adv_ld_n (adv_ld_n),
    .we_n     (we_n),
    .sel_all  (sel_all),
    .oe_n     (oe_n),
    .s2_vld   (s2_vld),
    .s2_wr    (s2_wr),
    .d_out    (d_out),
    .d_oe     (d_oe)
);

// File: tb/nt_sram_tb.sv
// Directed bench for nt_sram with a cycle-level reference model.
`timescale 1ns/100ps
module nt_sram_tb;

    localparam int AW    = 6;
    localparam int LANES = 4;
    localparam int LW    = 9;
    localparam int DW    = LANES*LW;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic             rst_n, clk_en_n, ce1_n, ce2, ce3_n, adv_ld_n, we_n;
    logic [LANES-1:0] bw_n;
    logic             burst_ilv, oe_n, d_oe;
    logic [AW-1:0]    addr;
    logic [DW-1:0]    d_in, d_out;

    nt_sram #(.AW(AW), .LANES(LANES), .LANE_W(LW)) u_dut (
        .clk(clk), .rst_n(rst_n), .clk_en_n(clk_en_n), .ce1_n(ce1_n),
        .ce2(ce2), .ce3_n(ce3_n), .adv_ld_n(adv_ld_n), .we_n(we_n),
        .bw_n(bw_n), .burst_ilv(burst_ilv), .addr(addr), .oe_n(oe_n),
        .d_in(d_in), .d_out(d_out), .d_oe(d_oe)
    );

    // reference model state
    logic             m1_vld, m1_wr, m2_vld, m2_wr;
    logic [AW-1:0]    m1_addr, m2_addr;
    logic [LANES-1:0] m1_bw, m2_bw;
    logic [DW-1:0]    m1_data, m2_data, exp_q;
    logic             b_act, b_wr, b_mode;
    logic [AW-1:0]    b_base;
    logic [1:0]       b_cnt;
    logic [DW-1:0]    ref_mem [1<<AW];

    int    n_tests = 0;
    int    n_fail  = 0;
    int    desel_cnt = 0;
    string cur_req = "R1";
    bit    done = 1'b0;

    task automatic chk(input bit ok, input string what,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", cur_req, what, act, exp);
        end
    endtask

    // one clock cycle: drive at negedge, model at posedge, check at negedge
    task automatic cyc(input bit cen, input bit desel, input bit adv, input bit we,
                       input logic [LANES-1:0] bw, input bit mode,
                       input logic [AW-1:0] a, input bit oe, input logic [DW-1:0] wd);
        logic [1:0] low;
        bit         exp_oe;
        int         k;
        k = desel_cnt % 3;
        if (desel) desel_cnt++;
        clk_en_n  = cen;
        ce1_n     = desel && (k == 0);
        ce2       = !(desel && (k == 1));
        ce3_n     = desel && (k == 2);
        adv_ld_n  = adv;
        we_n      = we;
        bw_n      = bw;
        burst_ilv = mode;
        addr      = a;
        oe_n      = oe;
        d_in      = (m2_vld && m2_wr) ? m2_data : 36'h5A5A5A5A5;
        @(posedge clk);
        if (!cen) begin
            if (m2_vld && m2_wr)
                for (int i = 0; i < LANES; i++)
                    if (!m2_bw[i]) ref_mem[m2_addr][i*LW +: LW] = d_in[i*LW +: LW];
            if (m1_vld && !m1_wr) exp_q = ref_mem[m1_addr];
            m2_vld = m1_vld; m2_wr = m1_wr; m2_addr = m1_addr;
            m2_bw = m1_bw; m2_data = m1_data;
            if (!adv) begin
                if (!desel) begin
                    m1_vld = 1; m1_wr = !we; m1_addr = a; m1_bw = bw; m1_data = wd;
                    b_act = 1; b_wr = !we; b_base = a; b_cnt = 0; b_mode = mode;
                end else begin
                    m1_vld = 0; b_act = 0;
                end
            end else if (b_act) begin
                b_cnt = b_cnt + 2'd1;
                low = b_mode ? (b_base[1:0] ^ b_cnt) : (b_base[1:0] + b_cnt);
                m1_vld = 1; m1_wr = b_wr; m1_addr = {b_base[AW-1:2], low};
                m1_bw = bw; m1_data = wd;
            end else begin
                m1_vld = 0;
            end
        end
        @(negedge clk);
        exp_oe = m2_vld && !m2_wr && !oe;
        chk(d_oe === exp_oe, "drive enable", {35'd0, d_oe}, {35'd0, exp_oe});
        chk(d_out === exp_q, "read data", d_out, exp_q);
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d,
                      input logic [LANES-1:0] bw = '0);
        cyc(0, 0, 0, 0, bw, 0, a, 0, d);
    endtask
    task automatic rd(input logic [AW-1:0] a, input bit mode = 0, input bit oe = 0);
        cyc(0, 0, 0, 1, '1, mode, a, oe, '0);
    endtask
    task automatic adv_c(input bit we, input bit desel,
                         input logic [LANES-1:0] bw = '1, input logic [DW-1:0] d = '0);
        cyc(0, desel, 1, we, bw, 1, 6'h2A, 0, d);
    endtask
    task automatic idle(input bit oe = 0);
        cyc(0, 1, 0, 1, '1, 0, '0, oe, '0);
    endtask
    task automatic stall();
        cyc(1, 0, 0, 0, '0, 0, 6'h0C, 0, 36'hFFFFFFFFF);
    endtask

    task automatic t_reset();
        cur_req = "R1";
        chk(d_oe === 1'b0, "drive enable in reset", {35'd0, d_oe}, '0);
        chk(d_out === '0, "output register in reset", d_out, '0);
    endtask

    task automatic t_single();
        cur_req = "R3";
        wr(5, 36'h123456789); wr(6, 36'h9ABCDEF01); idle(); idle();
        rd(5); rd(6); idle(); idle();
        cur_req = "R6";
        rd(5); wr(7, 36'h0F0F0F0F0); rd(6); wr(8, 36'hE1E2E3E4E); rd(7); rd(8);
        idle(); idle();
    endtask

    task automatic t_forward();
        cur_req = "R11";
        wr(9, 36'h111111111); rd(9); wr(9, 36'hA5A5A5A5A, 4'b0110); rd(9);
        idle(); idle(); rd(9); idle(); idle();
    endtask

    task automatic t_lanes();
        cur_req = "R7";
        wr(10, 36'h876543210); wr(10, 36'hFFFFFFFFF, 4'b1010); idle(); idle();
        rd(10); wr(11, 36'h000000000); wr(11, 36'h1FF000000, 4'b0111); idle();
        rd(11); idle(); idle();
    endtask

    task automatic t_burst_lin();
        cur_req = "R8";
        for (int i = 0; i < 4; i++) wr(12 + i, 36'h100000000 + i * 36'h010101);
        idle(); idle();
        rd(14, 0); adv_c(0, 1); adv_c(0, 0); adv_c(1, 1); adv_c(1, 0); idle(); idle();
    endtask

    task automatic t_burst_ilv();
        cur_req = "R9";
        rd(13, 1); adv_c(1, 0); adv_c(1, 0); adv_c(1, 0); idle(); idle();
    endtask

    task automatic t_burst_wr();
        cur_req = "R10";
        cyc(0, 0, 0, 0, '0, 0, 17, 0, 36'h2AAAAAAAA);
        adv_c(1, 1, '0, 36'h255555555);
        adv_c(1, 1, 4'b1100, 36'h2C3C3C3C3);
        adv_c(1, 0, '0, 36'h2DEADBEEF);
        idle(); idle();
        rd(16); rd(17); rd(18); rd(19); idle(); idle();
    endtask

    task automatic t_stall();
        cur_req = "R2";
        rd(12); adv_c(0, 0); stall(); stall(); stall(); adv_c(0, 0); adv_c(0, 0);
        idle(); stall(); idle();
    endtask

    task automatic t_oe();
        cur_req = "R4";
        rd(5, 0, 1); idle(1);
        oe_n = 1'b0; #1;
        chk(d_oe === 1'b1, "drive enable after oe low", {35'd0, d_oe}, 36'd1);
        oe_n = 1'b1; #1;
        chk(d_oe === 1'b0, "drive enable after oe high", {35'd0, d_oe}, 36'd0);
        idle(); idle();
    endtask

    task automatic t_desel();
        cur_req = "R5";
        rd(6); rd(5); idle(); idle(); rd(7); idle(); idle();
        cur_req = "R12";
        adv_c(1, 0); adv_c(0, 0); idle(); rd(8); idle(); adv_c(1, 0); adv_c(1, 0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 0; clk_en_n = 0; ce1_n = 1; ce2 = 0; ce3_n = 1; adv_ld_n = 0;
        we_n = 1; bw_n = '1; burst_ilv = 0; addr = '0; oe_n = 0; d_in = '0;
        m1_vld = 0; m1_wr = 0; m2_vld = 0; m2_wr = 0; m1_addr = '0; m2_addr = '0;
        m1_bw = '1; m2_bw = '1; m1_data = '0; m2_data = '0; exp_q = '0;
        b_act = 0; b_wr = 0; b_mode = 0; b_base = '0; b_cnt = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        t_reset();
        rst_n = 1;
        t_single();
        t_forward();
        t_lanes();
        t_burst_lin();
        t_burst_ilv();
        t_burst_wr();
        t_stall();
        t_oe();
        t_desel();
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule